// File: doc/BRIEF.md
# Cache Line Refill Controller with Early Processor Release

This block runs the refill of a single cache line after a read miss. Once the surrounding cache reports a miss, the controller issues one memory request per word of the line over a valid/ready request channel and writes each returned word into an internal line buffer. The processor is released in the same cycle that the word it asked for comes back from memory. It does not wait for the rest of the line, and it can keep reading words of that line while the remaining words are still being fetched.

A mode input picks the fetch order when a refill starts. With wrap ordering selected, the first request goes to the missed word and the sequence then climbs through the line modulo its length. With linear ordering selected, the sequence runs from word 0 upward. A per-word valid vector records which words have already landed. A read to the line being filled is answered at once if its word is already there, and otherwise waits until that word arrives. A miss to any other line is held off until the current refill has finished.

The controller has three states. `S_IDLE`: no refill is in progress. `S_WAIT_CRIT`: a refill is running and the missed word has not yet arrived. `S_STREAM`: the missed word has been delivered and the rest of the line is being filled. The transitions are:
- `accept` (`S_IDLE` to `S_WAIT_CRIT`).
- `crit_arrive` (`S_WAIT_CRIT` to `S_STREAM`).
- `crit_is_last` (`S_WAIT_CRIT` to `S_IDLE`, taken when the missed word is the final word fetched).
- `fill_done` (`S_STREAM` to `S_IDLE`).

Top module: `line_refill_ctrl`

## Requirements
- R1: In idle, a cycle with `cpu_req` and `cpu_miss` both high accepts a refill of the line holding `cpu_addr`. `busy` is high from the next cycle until the cycle after the eighth response is accepted. `wrap_mode` is sampled only in the accepting cycle.
- R2: With `wrap_mode`=1 at acceptance, the word offsets requested (the low 3 bits of `mem_req_addr`) are m, m+1, … modulo 8, where m is the low 3 bits of the missed `cpu_addr`. The upper address bits are the missed line.
- R3: With `wrap_mode`=0 at acceptance, the word offsets requested are 0, 1, … 7 in ascending order.
- R4: Exactly 8 requests are issued per refill. `mem_req_valid` is high exactly while busy with requests still to issue, and `mem_req_addr` holds steady until `mem_req_ready` takes it. `mem_rsp_ready` equals `busy`.
- R5: When a response is accepted that carries the word an outstanding same-line `cpu_req` is waiting for, `cpu_rvalid` is high in that same cycle and `cpu_rdata` equals `mem_rsp_data`. With memory that is always ready and has one cycle of response latency, the release comes 2+p cycles after the accepting cycle, where p is the word's position in the fetch order.
- R6: `cpu_stall` is high when `cpu_req` is high, `cpu_rvalid` is low, and either a refill is busy or `cpu_miss` is high.
- R7: During a refill, a read to the line being filled whose word has already arrived is answered in the same cycle from the line buffer.
- R8: During a refill, a read to the line being filled whose word has not arrived stalls until that word's response is accepted.
- R9: During a refill, a request to a different line is neither answered nor accepted as a miss. Once the refill ends, a held miss to that line starts a new refill.
- R10: `line_valid` rises in the cycle after the eighth response is accepted, never earlier, and clears when the next refill is accepted.
- R11: After reset, `busy`, `mem_req_valid` and `line_valid` are low.
- R12: While busy, `cpu_miss` has no effect. A same-line read that carries `cpu_miss` is handled as a plain read of the line being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrap_mode | input | 1 | 1: fetch starts at the missed word and wraps; 0: fetch starts at word 0 |
| cpu_req | input | 1 | Processor read request, held until answered |
| cpu_miss | input | 1 | Tag lookup reports a miss for `cpu_addr` |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_rvalid | output | 1 | Read data valid, answers the held request |
| cpu_rdata | output | DATA_W | Read data |
| cpu_stall | output | 1 | Processor must wait |
| busy | output | 1 | Refill in progress |
| line_valid | output | 1 | All words of the last refilled line are written |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Word address requested |
| mem_rsp_valid | input | 1 | Memory response valid, in request order |
| mem_rsp_ready | output | 1 | Controller takes the response |
| mem_rsp_data | input | DATA_W | Response word |

## Verification
The hardest situation to reach is a processor read that lands in the middle of a refill: after the release, while some words of the line have arrived and others have not, and while the memory is pausing. The bench reaches it with a slow memory mode that withholds request readiness and response validity on fixed cycle patterns. That stretches each refill over many cycles, so that follow-up reads to arrived words, to missing words, and to another line all fall inside the refill window. A cycle-level reference model compares every output on every clock. The model does this for all eight missed offsets in both fetch orders, and it also times the release cycle.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_WAIT_CRIT = 2'd1,
        S_STREAM    = 2'd2
    } fill_state_e;
endpackage

// File: rtl/refill_seq.sv
module refill_seq #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFF_W-1:0] start_off,
    input  logic             req_fire,
    input  logic             rsp_fire,
    output logic [OFF_W-1:0] req_off,
    output logic [OFF_W-1:0] rsp_off,
    output logic             req_left,
    output logic             rsp_last
);
    localparam logic [OFF_W:0]   CNT_FULL = (OFF_W+1)'(WORDS);
    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(WORDS - 1);

    logic [OFF_W-1:0] base_q;
    logic [OFF_W:0]   req_cnt_q;
    logic [OFF_W-1:0] rsp_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
        end else if (start) begin
            base_q    <= start_off;
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
        end else begin
            if (req_fire) req_cnt_q <= req_cnt_q + 1'b1;
            if (rsp_fire) rsp_cnt_q <= rsp_cnt_q + 1'b1;
        end
    end

    // offsets wrap naturally: WORDS is a power of two
    always_comb begin
        req_off  = base_q + req_cnt_q[OFF_W-1:0];
        rsp_off  = base_q + rsp_cnt_q;
        req_left = req_cnt_q < CNT_FULL;
        rsp_last = rsp_cnt_q == LAST_IDX;
    end

    // R4: never more than WORDS requests per refill
    a_r4_req_bound: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |-> (req_cnt_q < CNT_FULL));
endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit
);
    logic [DATA_W-1:0] words_q [WORDS];
    logic [WORDS-1:0]  valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_off] <= wr_data;
    end

    always_comb begin
        rd_data = words_q[rd_off];
        rd_hit  = valid_q[rd_off];
    end

    // R4/R7: each word of the line is written exactly once per refill
    a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |-> !valid_q[wr_off]);
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
    import refill_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_mode,
    input  logic              cpu_req,
    input  logic              cpu_miss,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              busy,
    output logic              line_valid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - OFF_W;

    fill_state_e       state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  crit_q;
    logic              line_valid_q;

    logic [OFF_W-1:0]  cpu_off, req_off, rsp_off;
    logic              same_line, accept, req_fire, rsp_fire;
    logic              req_left, rsp_last, buf_hit, arrive_now;
    logic [DATA_W-1:0] buf_data;

    assign cpu_off   = cpu_addr[OFF_W-1:0];
    assign same_line = cpu_addr[ADDR_W-1:OFF_W] == line_q;
    assign accept    = (state_q == S_IDLE) && cpu_req && cpu_miss;
    assign req_fire  = mem_req_valid && mem_req_ready;
    assign rsp_fire  = mem_rsp_valid && mem_rsp_ready;

    refill_seq #(.WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_off (wrap_mode ? cpu_off : '0),
        .req_fire  (req_fire),
        .rsp_fire  (rsp_fire),
        .req_off   (req_off),
        .rsp_off   (rsp_off),
        .req_left  (req_left),
        .rsp_last  (rsp_last)
    );

    refill_linebuf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .wr_en   (rsp_fire),
        .wr_off  (rsp_off),
        .wr_data (mem_rsp_data),
        .rd_off  (cpu_off),
        .rd_data (buf_data),
        .rd_hit  (buf_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (accept) state_d = S_WAIT_CRIT;
            S_WAIT_CRIT: if (rsp_fire && rsp_off == crit_q)
                             state_d = rsp_last ? S_IDLE : S_STREAM;
            S_STREAM:    if (rsp_fire && rsp_last) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register and refill context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            line_q       <= '0;
            crit_q       <= '0;
            line_valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                line_q       <= cpu_addr[ADDR_W-1:OFF_W];
                crit_q       <= cpu_off;
                line_valid_q <= 1'b0;
            end else if (rsp_fire && rsp_last) begin
                line_valid_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = state_q != S_IDLE;
        line_valid    = line_valid_q;
        mem_req_valid = busy && req_left;
        mem_req_addr  = {line_q, req_off};
        mem_rsp_ready = busy;
        arrive_now    = rsp_fire && (rsp_off == cpu_off);
        cpu_rvalid    = busy && cpu_req && same_line && (buf_hit || arrive_now);
        cpu_rdata     = buf_hit ? buf_data : mem_rsp_data;
        cpu_stall     = cpu_req && !cpu_rvalid && (busy || cpu_miss);
    end

    // R1: an accepted miss makes the controller busy next cycle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R2: wrap order starts at the missed word
    a_r2_first_req_crit: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wrap_mode) |=>
            (mem_req_valid && mem_req_addr == $past(cpu_addr)));
    // R3: linear order starts at word 0
    a_r3_first_req_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wrap_mode) |=>
            (mem_req_valid && mem_req_addr[OFF_W-1:0] == '0));
    // R4: a pending request holds its address
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr)));
    // R9: other-line requests wait while busy
    a_r9_other_line_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_req && !same_line) |-> (cpu_stall && !cpu_rvalid));
    // R10: the line becomes valid only after a response was taken
    a_r10_line_valid_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> $past(rsp_fire));
endmodule

// File: tb/sim_line_refill_ctrl.sv
module sim_line_refill_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wrap_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_miss = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rvalid, cpu_stall, busy, line_valid;
    logic [31:0] cpu_rdata;
    logic        mem_req_valid, mem_rsp_ready;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    line_refill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wrap_mode(wrap_mode),
        .cpu_req(cpu_req), .cpu_miss(cpu_miss), .cpu_addr(cpu_addr),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .busy(busy), .line_valid(line_valid),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
    );

    int n_cmp = 0;
    int n_mis = 0;
    int cyc = 0;
    bit slow = 1'b0;
    logic [15:0] mq[$];

    // reference model state
    bit          m_busy = 0, m_lv = 0, m_wrap = 0;
    logic [12:0] m_line = '0;
    int          m_start = 0, m_reqs = 0, m_rsps = 0;
    bit          m_arr[8];

    function automatic logic [31:0] memfn(input logic [15:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    endtask

    // memory responder: in-order, patterns stretch timing in slow mode
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_req_ready <= slow ? ((cyc % 2) == 0) : 1'b1;
            mem_rsp_valid <= (mq.size() > 0) && (slow ? ((cyc % 3) != 1) : 1'b1);
            mem_rsp_data  <= (mq.size() > 0) ? memfn(mq[0]) : 32'h0;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit rq_f, rs_f, exp_rv, exp_stall;
            int r_off, c_off;
            string tag;
            cyc++;
            if (cyc > 100000) begin
                n_cmp++; n_mis++;
                $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
                finish_run();
            end
            rq_f  = mem_req_valid && mem_req_ready;
            rs_f  = mem_rsp_valid && mem_rsp_ready;
            r_off = (mq.size() > 0) ? int'(mq[0][2:0]) : -1;
            c_off = int'(cpu_addr[2:0]);

            chk(busy == m_busy, "R1", "busy", busy, m_busy);
            chk(line_valid == m_lv, "R10", "line_valid", line_valid, m_lv);
            chk(mem_req_valid == (m_busy && m_reqs < 8), "R4", "mem_req_valid",
                mem_req_valid, m_busy && m_reqs < 8);
            chk(mem_rsp_ready == m_busy, "R4", "mem_rsp_ready", mem_rsp_ready, m_busy);
            if (mem_req_valid && m_busy)
                chk(mem_req_addr == {m_line, 3'((m_start + m_reqs) % 8)},
                    m_wrap ? "R2" : "R3", "mem_req_addr", mem_req_addr,
                    {m_line, 3'((m_start + m_reqs) % 8)});
            if (rs_f && r_off < 0) chk(1'b0, "R4", "response without request", 1, 0);

            exp_rv = 1'b0;
            tag = "R9";
            if (m_busy && cpu_req && cpu_addr[15:3] == m_line) begin
                if (m_arr[c_off]) begin exp_rv = 1'b1; tag = "R7"; end
                else if (rs_f && r_off == c_off) begin exp_rv = 1'b1; tag = "R5"; end
                else tag = "R8";
            end
            if (m_busy && cpu_req && cpu_miss && tag != "R9") tag = {tag, "/R12"};
            chk(cpu_rvalid == exp_rv, tag, "cpu_rvalid", cpu_rvalid, exp_rv);
            if (exp_rv && cpu_rvalid)
                chk(cpu_rdata == memfn(cpu_addr), tag, "cpu_rdata", cpu_rdata, memfn(cpu_addr));
            exp_stall = cpu_req && !exp_rv && (m_busy || cpu_miss);
            chk(cpu_stall == exp_stall, "R6", "cpu_stall", cpu_stall, exp_stall);

            // advance responder and model to the state after the next edge
            if (rq_f) mq.push_back(mem_req_addr);
            if (rs_f && mq.size() > 0) void'(mq.pop_front());
            if (!m_busy) begin
                if (cpu_req && cpu_miss) begin
                    m_busy = 1; m_lv = 0; m_wrap = wrap_mode;
                    m_line = cpu_addr[15:3];
                    m_start = wrap_mode ? c_off : 0;
                    m_reqs = 0; m_rsps = 0;
                    foreach (m_arr[i]) m_arr[i] = 0;
                end
            end else begin
                if (rq_f) m_reqs++;
                if (rs_f && r_off >= 0) begin
                    m_arr[r_off] = 1;
                    m_rsps++;
                    if (m_rsps == 8) begin m_busy = 0; m_lv = 1; end
                end
            end
        end
    end

    // hold a read until answered; returns negedges from drive to release
    task automatic cpu_read(input logic [15:0] a, input bit miss, output int n);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_miss = miss; cpu_addr = a;
        n = 0;
        forever begin
            @(negedge clk);
            if (cpu_rvalid) break;
            n++;
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_miss = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    initial begin
        int n;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R11", "busy in reset", busy, 0);
        chk(mem_req_valid == 1'b0, "R11", "mem_req_valid in reset", mem_req_valid, 0);
        chk(line_valid == 1'b0, "R11", "line_valid in reset", line_valid, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2/R3/R5: every offset, both orders, fast memory, release timing
        for (int md = 1; md >= 0; md--) begin
            for (int off = 0; off < 8; off++) begin
                logic [15:0] a;
                a = {13'(16 * md + off + 3), 3'(off)};
                wrap_mode = md[0];
                cpu_read(a, 1'b1, n);
                chk(n == 2 + (md == 1 ? 0 : off), md == 1 ? "R5/R2" : "R5/R3",
                    "release cycle", n, 2 + (md == 1 ? 0 : off));
                wait_idle();
                chk(line_valid == 1'b1, "R10", "line_valid after fill", line_valid, 1);
            end
        end

        // slow memory: reads land mid-refill
        slow = 1'b1;
        wrap_mode = 1'b1;
        cpu_read(16'h1235, 1'b1, n);          // miss, wrap from word 5
        wrap_mode = 1'b0;                     // R1: ignored mid-refill
        cpu_read(16'h1235, 1'b0, n);          // R7: arrived word
        chk(n == 0, "R7", "arrived word served at once", n, 0);
        cpu_read(16'h1234, 1'b1, n);          // R8/R12: last word in wrap order
        chk(n > 0, "R8", "missing word stalls", n, 1);
        wait_idle();

        wrap_mode = 1'b0;
        cpu_read(16'h2F03, 1'b1, n);          // linear, miss on word 3
        cpu_read(16'h2F01, 1'b0, n);          // R7
        chk(n == 0, "R7", "earlier word served at once", n, 0);
        chk(busy == 1'b1, "R9", "still busy before other-line miss", busy, 1);
        cpu_read(16'h0A46, 1'b1, n);          // R9: other line waits, then refills
        chk(n > 3, "R9", "other-line miss held off", n, 4);
        wait_idle();
        chk(line_valid == 1'b1, "R10", "line_valid after second fill", line_valid, 1);

        slow = 1'b0;
        wrap_mode = 1'b1;
        cpu_read(16'h0007, 1'b1, n);
        chk(n == 2, "R5", "wrap release at last offset", n, 2);
        wait_idle();
        finish_run();
    end
endmodule